// File: doc/BRIEF.md
# Microprocessor Bus Cycle Classifier

This block sits beside an 8-bit microprocessor bus and only listens. On every tick of its own monitor clock it samples the five active-low control strobes, the address lines and the data lines. It passes them through a synchronizer and sorts the sample into one of six machine-cycle kinds, or into "no cycle". It turns changes of that kind into one-clock begin, end and error pulses. It captures the address when a cycle opens and keeps the most recent data byte seen while a cycle is active.

A trace or debug unit uses the pulses and the captured values to log bus traffic without touching the bus. When the bus moves straight from one active cycle kind to a different one, with no idle sample between them, the block reports a protocol violation. It then drops the address and data it had gathered for that cycle.

Top module: `bcyc_monitor`

## Requirements
- R1: While the memory strobe is low and the read strobe is low, the kind is 5 (opcode fetch) if the M1 strobe is low, and 1 (memory read) otherwise.
- R2: While the memory strobe is low, the read strobe is high and the write strobe is low, the kind is 2 (memory write).
- R3: Memory decoding has priority. The I/O strobe is ignored whenever the memory strobe is low. With both request strobes high, or with the memory strobe low but both read and write high, the kind is 0 (none).
- R4: With the memory strobe high and the I/O strobe low, the kind is 6 (interrupt acknowledge) if M1 is low. Otherwise it is 3 (I/O read) if read is low, 4 (I/O write) if write is low, and 0 if neither is low.
- R5: `cyc_begin` pulses for one clock when the kind goes from 0 to non-zero. `cap_addr` loads the sampled address only at that moment.
- R6: `cap_data` loads the sampled data byte on every sample whose kind is non-zero. It holds its value while the kind is 0.
- R7: A change from one non-zero kind to a different non-zero kind pulses `cyc_illegal` for one clock and clears `cap_addr` and `cap_data` to zero. The data of that sample is discarded as well.
- R8: When the kind goes from non-zero to 0, `cyc_end` pulses for one clock and `end_kind` takes the kind of the finished cycle. `end_kind` holds that value until the next end.
- R9: Every output reflects a bus sample SYNC_STAGES+1 clock edges after the sample is applied. `live_kind` shows the kind of that sample.
- R10: Synchronous active-high reset sets all outputs to zero. The previous kind becomes 0, and the synchronizer holds idle strobes (all high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_m1_n | input | 1 | First-machine-cycle strobe, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_mreq_n | input | 1 | Memory request strobe, active low |
| bus_iorq_n | input | 1 | I/O request strobe, active low |
| bus_addr | input | ADDR_W | Address lines |
| bus_data | input | DATA_W | Data lines |
| live_kind | output | 3 | Kind of the current synchronized sample |
| cyc_begin | output | 1 | One-clock pulse when a cycle opens |
| cyc_end | output | 1 | One-clock pulse when a cycle closes |
| cyc_illegal | output | 1 | One-clock pulse on a direct change between active kinds |
| end_kind | output | 3 | Kind of the most recently finished cycle |
| cap_addr | output | ADDR_W | Address captured when the cycle opened |
| cap_data | output | DATA_W | Latest data byte of the active cycle |

## Verification
The bench builds the block with its defaults: a 16-bit address, an 8-bit data byte and a two-stage synchronizer. This fixes the latency at three edges. The 5-bit control space then has only 32 patterns, so the bench runs every ordered pair of patterns as idle, first, first, second, second, idle. That covers every decode row, every begin, every end, and every legal and illegal transition between kinds, including transitions where the kind does not change. The address and data values change on every sample. This shows that the address loads only when a cycle opens and that data follows each active sample.

// File: rtl/bcyc_pkg.sv
package bcyc_pkg;

   typedef enum logic [2:0] {
      K_NONE   = 3'd0,
      K_MEMRD  = 3'd1,
      K_MEMWR  = 3'd2,
      K_IORD   = 3'd3,
      K_IOWR   = 3'd4,
      K_FETCH  = 3'd5,
      K_INTACK = 3'd6
   } kind_e;

   localparam int CTL_W = 5;

   typedef struct packed {
      logic iorq_n;
      logic mreq_n;
      logic wr_n;
      logic rd_n;
      logic m1_n;
   } ctl_s;

   localparam ctl_s CTL_IDLE = '{iorq_n: 1'b1, mreq_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1, m1_n: 1'b1};

endpackage

// File: rtl/bcyc_sync.sv
module bcyc_sync #(
   parameter int              W       = 8,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("bcyc_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("bcyc_sync: W must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) stg[0] <= RST_VAL;
            else     stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) stg[i] <= RST_VAL;
            else     stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/bcyc_decode.sv
module bcyc_decode
   import bcyc_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  ctl_s  ctl,
   output kind_e kind
);
   always_comb begin
      kind = K_NONE;
      if (!ctl.mreq_n) begin
         if (!ctl.rd_n)      kind = ctl.m1_n ? K_MEMRD : K_FETCH;
         else if (!ctl.wr_n) kind = K_MEMWR;
      end else if (!ctl.iorq_n) begin
         if (!ctl.m1_n)      kind = K_INTACK;
         else if (!ctl.rd_n) kind = K_IORD;
         else if (!ctl.wr_n) kind = K_IOWR;
      end
   end

   // R3: with memory request low, the result is a memory kind or none
   p_mem_priority_r3: assert property (@(posedge clk) disable iff (rst)
      !ctl.mreq_n |-> (kind inside {K_NONE, K_MEMRD, K_MEMWR, K_FETCH}));

   // R4: I/O kinds only appear with memory request high and I/O request low
   p_io_gate_r4: assert property (@(posedge clk) disable iff (rst)
      (kind inside {K_IORD, K_IOWR, K_INTACK}) |-> (ctl.mreq_n && !ctl.iorq_n));
endmodule

// File: rtl/bcyc_tracker.sv
module bcyc_tracker
   import bcyc_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  kind_e             now_kind,
   input  logic [ADDR_W-1:0] s_addr,
   input  logic [DATA_W-1:0] s_data,
   output kind_e             prev_kind,
   output logic              beg_p,
   output logic              end_p,
   output logic              ill_p,
   output kind_e             end_kind,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q
);
   logic opening, closing, clash;

   assign opening = (prev_kind == K_NONE) && (now_kind != K_NONE);
   assign closing = (prev_kind != K_NONE) && (now_kind == K_NONE);
   assign clash   = (prev_kind != K_NONE) && (now_kind != K_NONE) && (now_kind != prev_kind);

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_kind <= K_NONE;
         beg_p     <= 1'b0;
         end_p     <= 1'b0;
         ill_p     <= 1'b0;
         end_kind  <= K_NONE;
         addr_q    <= '0;
         data_q    <= '0;
      end else begin
         prev_kind <= now_kind;
         beg_p     <= opening;
         end_p     <= closing;
         ill_p     <= clash;
         if (closing) end_kind <= prev_kind;
         if (clash) begin
            addr_q <= '0;
            data_q <= '0;
         end else begin
            if (opening)             addr_q <= s_addr;
            if (now_kind != K_NONE)  data_q <= s_data;
         end
      end
   end

   // R5: a begin pulse follows an idle sample and shows an active kind
   p_begin_edge_r5: assert property (@(posedge clk) disable iff (rst)
      beg_p |-> ($past(prev_kind) == K_NONE && prev_kind != K_NONE));

   // R5: the captured address moves only on begin or on a discard
   p_addr_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (!beg_p && !ill_p) |-> $stable(addr_q));

   // R6: data is held while no cycle is active
   p_data_idle_r6: assert property (@(posedge clk) disable iff (rst)
      (prev_kind == K_NONE) |-> $stable(data_q));

   // R7: an illegal transition leaves the captures cleared
   p_clash_clear_r7: assert property (@(posedge clk) disable iff (rst)
      ill_p |-> (addr_q == '0 && data_q == '0));

   // R8: an end pulse reports the kind that was active one sample earlier
   p_end_kind_r8: assert property (@(posedge clk) disable iff (rst)
      end_p |-> (prev_kind == K_NONE && end_kind != K_NONE && end_kind == $past(prev_kind)));

   // R9: the three event pulses never coincide
   p_pulse_excl_r9: assert property (@(posedge clk) disable iff (rst)
      $onehot0({beg_p, end_p, ill_p}));
endmodule

// File: rtl/bcyc_monitor.sv
module bcyc_monitor
   import bcyc_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_m1_n,
   input  logic              bus_rd_n,
   input  logic              bus_wr_n,
   input  logic              bus_mreq_n,
   input  logic              bus_iorq_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   output logic [2:0]        live_kind,
   output logic              cyc_begin,
   output logic              cyc_end,
   output logic              cyc_illegal,
   output logic [2:0]        end_kind,
   output logic [ADDR_W-1:0] cap_addr,
   output logic [DATA_W-1:0] cap_data
);
   localparam int BUS_W = CTL_W + ADDR_W + DATA_W;
   localparam logic [BUS_W-1:0] BUS_IDLE = {CTL_IDLE, {(ADDR_W+DATA_W){1'b0}}};

   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("bcyc_monitor: ADDR_W and DATA_W must be positive");
   end

   logic [BUS_W-1:0]  raw_bus, s_bus;
   ctl_s              s_ctl;
   logic [ADDR_W-1:0] s_addr;
   logic [DATA_W-1:0] s_data;
   kind_e             now_kind, prev_kind, end_k;

   assign raw_bus = {bus_iorq_n, bus_mreq_n, bus_wr_n, bus_rd_n, bus_m1_n, bus_addr, bus_data};

   bcyc_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) u_sync (
      .clk(clk), .rst(rst), .d(raw_bus), .q(s_bus)
   );

   assign s_ctl  = ctl_s'(s_bus[BUS_W-1 -: CTL_W]);
   assign s_addr = s_bus[DATA_W +: ADDR_W];
   assign s_data = s_bus[DATA_W-1:0];

   bcyc_decode u_dec (
      .clk(clk), .rst(rst), .ctl(s_ctl), .kind(now_kind)
   );

   bcyc_tracker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_trk (
      .clk(clk), .rst(rst), .now_kind(now_kind), .s_addr(s_addr), .s_data(s_data),
      .prev_kind(prev_kind), .beg_p(cyc_begin), .end_p(cyc_end), .ill_p(cyc_illegal),
      .end_kind(end_k), .addr_q(cap_addr), .data_q(cap_data)
   );

   assign live_kind = prev_kind;
   assign end_kind  = end_k;
endmodule

// File: tb/tb_bcyc_monitor.sv
module tb_bcyc_monitor;
   localparam int AW  = 16;
   localparam int DW  = 8;
   localparam int SS  = 2;
   localparam int LAT = SS + 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic m1_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, mreq_n = 1'b1, iorq_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] data = '0;
   logic [2:0] live_kind, end_kind;
   logic cyc_begin, cyc_end, cyc_illegal;
   logic [AW-1:0] cap_addr;
   logic [DW-1:0] cap_data;

   always #2 clk = ~clk;

   bcyc_monitor #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(SS)) dut (
      .clk(clk), .rst(rst), .bus_m1_n(m1_n), .bus_rd_n(rd_n), .bus_wr_n(wr_n),
      .bus_mreq_n(mreq_n), .bus_iorq_n(iorq_n), .bus_addr(addr), .bus_data(data),
      .live_kind(live_kind), .cyc_begin(cyc_begin), .cyc_end(cyc_end),
      .cyc_illegal(cyc_illegal), .end_kind(end_kind), .cap_addr(cap_addr), .cap_data(cap_data)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // control vector bits: [4]=iorq_n [3]=mreq_n [2]=wr_n [1]=rd_n [0]=m1_n
   function automatic logic [2:0] ref_kind(input logic [4:0] c);
      if (!c[3]) begin
         if (!c[1]) return c[0] ? 3'd1 : 3'd5;
         if (!c[2]) return 3'd2;
         return 3'd0;
      end
      if (!c[4]) begin
         if (!c[0]) return 3'd6;
         if (!c[1]) return 3'd3;
         if (!c[2]) return 3'd4;
      end
      return 3'd0;
   endfunction

   function automatic string kind_tag(input logic [4:0] c);
      if (!c[3] && !c[4]) return "R3";
      if (!c[3] && !c[1]) return "R1";
      if (!c[3] && !c[2]) return "R2";
      if (!c[3])          return "R3";
      if (!c[4])          return "R4";
      return "R3";
   endfunction

   // reference state
   logic [2:0]    m_prev = 3'd0, m_endk = 3'd0;
   logic [AW-1:0] m_addr = '0;
   logic [DW-1:0] m_data = '0;

   // expectation ring, indexed by step modulo 4
   logic [4:0]    e_ctl  [4];
   logic [2:0]    e_kind [4];
   logic [2:0]    e_endk [4];
   logic          e_beg  [4];
   logic          e_end  [4];
   logic          e_ill  [4];
   logic [AW-1:0] e_addr [4];
   logic [DW-1:0] e_data [4];
   int step = 0;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h (step %0d)", tag, what, act, exp, step);
      end
   endtask

   task automatic compare(input int k);
      int i = k % 4;
      chk(kind_tag(e_ctl[i]), "live_kind R9", int'(live_kind), int'(e_kind[i]));
      chk("R5/R9", "cyc_begin", int'(cyc_begin), int'(e_beg[i]));
      chk("R5", "cap_addr", int'(cap_addr), int'(e_addr[i]));
      chk("R6", "cap_data", int'(cap_data), int'(e_data[i]));
      chk("R7", "cyc_illegal", int'(cyc_illegal), int'(e_ill[i]));
      chk("R8", "cyc_end", int'(cyc_end), int'(e_end[i]));
      chk("R8", "end_kind", int'(end_kind), int'(e_endk[i]));
   endtask

   // one bus sample: check the result of the sample LAT steps back, then drive
   task automatic apply(input logic [4:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d);
      logic [2:0] now;
      logic beg, fin, ill;
      int i;
      @(negedge clk);
      if (step >= LAT) compare(step - LAT);
      {iorq_n, mreq_n, wr_n, rd_n, m1_n} = c;
      addr = a;
      data = d;
      now = ref_kind(c);
      beg = (m_prev == 3'd0) && (now != 3'd0);
      fin = (m_prev != 3'd0) && (now == 3'd0);
      ill = (m_prev != 3'd0) && (now != 3'd0) && (now != m_prev);
      if (fin) m_endk = m_prev;
      if (ill) begin
         m_addr = '0;
         m_data = '0;
      end else begin
         if (beg) m_addr = a;
         if (now != 3'd0) m_data = d;
      end
      m_prev = now;
      i = step % 4;
      e_ctl[i] = c;  e_kind[i] = now; e_endk[i] = m_endk;
      e_beg[i] = beg; e_end[i] = fin; e_ill[i] = ill;
      e_addr[i] = m_addr; e_data[i] = m_data;
      step++;
   endtask

   function automatic logic [AW-1:0] addr_of(input int n);
      return AW'(n * 16'h1357 + 16'h00A1);
   endfunction

   function automatic logic [DW-1:0] data_of(input int n);
      return DW'(n * 37 + 5);
   endfunction

   initial begin : watchdog
      int cyc = 0;
      while (!done && cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R10: outputs are zero under reset
      chk("R10", "live_kind", int'(live_kind), 0);
      chk("R10", "cyc_begin", int'(cyc_begin), 0);
      chk("R10", "cyc_end", int'(cyc_end), 0);
      chk("R10", "cyc_illegal", int'(cyc_illegal), 0);
      chk("R10", "end_kind", int'(end_kind), 0);
      chk("R10", "cap_addr", int'(cap_addr), 0);
      chk("R10", "cap_data", int'(cap_data), 0);
      rst = 1'b0;
      for (int a = 0; a < 32; a++) begin
         for (int b = 0; b < 32; b++) begin
            apply(5'h1F, addr_of(step), data_of(step));
            apply(5'(a), addr_of(step), data_of(step));
            apply(5'(a), addr_of(step), data_of(step));
            apply(5'(b), addr_of(step), data_of(step));
            apply(5'(b), addr_of(step), data_of(step));
            apply(5'h1F, addr_of(step), data_of(step));
         end
      end
      for (int f = 0; f < LAT + 1; f++) apply(5'h1F, addr_of(step), data_of(step));
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule